// File: doc/BRIEF.md
# Line Sag and Fault Detector

This block watches one stream of signed two's-complement instantaneous samples, voltage or current, which arrive one per strobe at the output word rate. It sets a sticky flag when the signal has stayed weak over a whole programmed window. A window holds exactly `dur` accepted strobes. Over that window the block adds up the sample magnitudes and counts how many samples fall under the level. At the last strobe it declares an event only if two conditions both hold. The average magnitude must be below the level. More than half of the samples must be individually below the level. The average test compares the sum with `lvl * dur`, so no divider is needed. A zero level or a zero duration turns detection off. One instance serves one channel. A voltage sag flag and a current fault flag come from two instances placed side by side.

A small controller sequences the windows. It has three states. In `S_OFF` detection is off, and the block waits for a non-zero level and duration. `S_ARM` is a single cycle that empties the accumulators before a window starts. In `S_RUN` strobes are accumulated and windows run back to back. The transitions are as follows:
- `S_OFF -> S_ARM` when detection becomes enabled.
- `S_ARM -> S_RUN` when the configuration is stable.
- `S_ARM -> S_ARM` and `S_RUN -> S_ARM` on any change of level or duration.
- Any state goes to `S_OFF` when the level or the duration becomes zero.

Top module: `sag_detector`

## Requirements
- R1: While reset is asserted, and after it is released, `flag` is 0.
- R2: A sample's magnitude is its absolute value. The most negative code (bit pattern 1 followed by all zeros) gives the largest positive code, 2^(SMP_W-1)-1.
- R3: Only strobes with `smp_vld` high count toward a window. A window closes on its `dur`-th counted strobe, and `flag` can rise only on the clock edge that accepts that strobe. Idle cycles between strobes do not change the count.
- R4: The average condition holds when the sum of magnitudes over the window is strictly less than `lvl * dur`. `lvl` is unsigned.
- R5: The majority condition holds when the number of samples whose magnitude is strictly less than `lvl` is more than half of `dur`, that is, twice the count is greater than `dur`. An event needs both R4 and R5.
- R6: When `dur` is 0 or `lvl` is 0, the detector is off. It never raises `flag`, and it discards the strobes it sees in that time.
- R7: A strobe is ignored in the cycle where `lvl` or `dur` differs from its value in the previous cycle. It is also ignored in the cycle after that. A fresh window begins with the next strobe.
- R8: `flag` is sticky. A `clr` pulse clears it on the next edge. A `clr` in the same cycle as a new event leaves `flag` set.
- R9: After a window closes, the next counted strobe begins a new window, whatever the outcome of the last one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | Strobe: `smp` holds a new sample |
| smp | input | SMP_W | Signed two's-complement instantaneous sample |
| lvl | input | SMP_W | Unsigned magnitude level |
| dur | input | DUR_W | Window length in strobes |
| clr | input | 1 | Pulse that clears the flag |
| flag | output | 1 | Sticky sag/fault indication |

## Verification
The hardest cases to reach are those where exactly one of the two window conditions fails. In one, the average is under the level while at most half of the samples are. In the other, most samples are under the level while one large sample pushes the sum to exactly `lvl * dur`. Directed windows build both cases sample by sample, at the exact boundary and one count inside it. A sweep over small window lengths and several levels then mixes low-amplitude and full-range patterns, and the bench works out the expected verdict from its own sum and count. Reaching a restart halfway through a window needs a level change in the same cycle as a strobe. The bench then counts how many strobes the flag takes to appear.

// File: rtl/sag_pkg.sv
package sag_pkg;
    typedef enum logic [1:0] {
        S_OFF = 2'd0,
        S_ARM = 2'd1,
        S_RUN = 2'd2
    } sag_state_t;
endpackage

// File: rtl/sag_mag.sv
module sag_mag #(
    parameter int W = 16
) (
    input  logic [W-1:0] smp,
    output logic [W-1:0] mag
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] MAX_POS  = {1'b0, {(W-1){1'b1}}};

    always_comb begin
        if (smp == MOST_NEG)
            mag = MAX_POS;
        else if (smp[W-1])
            mag = ~smp + 1'b1;
        else
            mag = smp;
    end

    // R2: magnitude never carries the sign bit
    always_comb begin
        if (!$isunknown(smp))
            a_r2_mag_positive: assert (mag[W-1] == 1'b0);
    end
endmodule

// File: rtl/sag_window.sv
module sag_window #(
    parameter int W  = 16,
    parameter int DW = 8,
    parameter int SW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_acc,
    input  logic          add,
    input  logic [W-1:0]  mag,
    input  logic          below,
    input  logic [DW-1:0] dur,
    output logic          last,
    output logic [SW-1:0] tot_sum,
    output logic [DW-1:0] tot_below
);
    logic [DW-1:0] cnt;
    logic [SW-1:0] sum_q;
    logic [DW-1:0] blw_q;

    assign last      = add && (cnt == dur - 1'b1);
    assign tot_sum   = sum_q + SW'(mag);
    assign tot_below = blw_q + DW'(below);

    always_ff @(posedge clk) begin
        if (!rst_n || clr_acc) begin
            cnt   <= '0;
            sum_q <= '0;
            blw_q <= '0;
        end else if (add) begin
            if (last) begin
                cnt   <= '0;
                sum_q <= '0;
                blw_q <= '0;
            end else begin
                cnt   <= cnt + 1'b1;
                sum_q <= tot_sum;
                blw_q <= tot_below;
            end
        end
    end

    // R3: a counted strobe always lands inside the programmed window
    a_r3_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
        add |-> (cnt < dur));
endmodule

// File: rtl/sag_detector.sv
module sag_detector
    import sag_pkg::*;
#(
    parameter int SMP_W = 16,
    parameter int DUR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_vld,
    input  logic [SMP_W-1:0] smp,
    input  logic [SMP_W-1:0] lvl,
    input  logic [DUR_W-1:0] dur,
    input  logic             clr,
    output logic             flag
);
    localparam int SUM_W = SMP_W + DUR_W;

    sag_state_t       state, nxt;
    logic [SMP_W-1:0] lvl_q;
    logic [DUR_W-1:0] dur_q;
    logic             en, cfg_chg, add, clr_acc, below, hit, flag_q;
    logic [SMP_W-1:0] mag;
    logic             win_last;
    logic [SUM_W-1:0] tot_sum, thresh;
    logic [DUR_W-1:0] tot_below;

    assign en      = (lvl != '0) && (dur != '0);
    assign cfg_chg = (lvl != lvl_q) || (dur != dur_q);
    assign add     = smp_vld && (state == S_RUN) && !cfg_chg && en;
    assign clr_acc = (state != S_RUN);
    assign below   = (mag < lvl);
    assign thresh  = SUM_W'(lvl) * SUM_W'(dur);

    sag_mag #(.W(SMP_W)) u_mag (
        .smp (smp),
        .mag (mag)
    );

    sag_window #(.W(SMP_W), .DW(DUR_W), .SW(SUM_W)) u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_acc   (clr_acc),
        .add       (add),
        .mag       (mag),
        .below     (below),
        .dur       (dur),
        .last      (win_last),
        .tot_sum   (tot_sum),
        .tot_below (tot_below)
    );

    assign hit = win_last && (tot_sum < thresh)
                 && ((DUR_W+1)'({tot_below, 1'b0}) > (DUR_W+1)'(dur));

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_OFF;
            lvl_q <= '0;
            dur_q <= '0;
        end else begin
            state <= nxt;
            lvl_q <= lvl;
            dur_q <= dur;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_OFF:   nxt = en ? S_ARM : S_OFF;
            S_ARM:   nxt = !en ? S_OFF : (cfg_chg ? S_ARM : S_RUN);
            S_RUN:   nxt = !en ? S_OFF : (cfg_chg ? S_ARM : S_RUN);
            default: nxt = S_OFF;
        endcase
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (hit)
            flag_q <= 1'b1;
        else if (clr)
            flag_q <= 1'b0;
    end

    assign flag = flag_q;

    // R8: flag holds without a clear
    a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
    // R8: a clear with no closing window empties the flag
    a_r8_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !win_last) |=> !flag);
    // R8: the flag only falls after a clear
    a_r8_fall_needs_clr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag) |-> $past(clr));
    // R6: no new event while disabled
    a_r6_off_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ((lvl == '0) || (dur == '0)) |=> !$rose(flag));
    // R7: no event in the cycle a configuration change is seen
    a_r7_restart_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_chg |=> !$rose(flag));
endmodule

// File: tb/sag_detector_bench.sv
`timescale 1ns/1ps
module sag_detector_bench;
    localparam int SW = 8;
    localparam int DW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n, smp_vld, clr, flag;
    logic [SW-1:0] smp, lvl;
    logic [DW-1:0] dur;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    sag_detector #(.SMP_W(SW), .DUR_W(DW)) u_sag_detector (
        .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp(smp),
        .lvl(lvl), .dur(dur), .clr(clr), .flag(flag)
    );

    task automatic check(input logic act, input logic exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: flag=%0b expected %0b", what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input int v);
        @(negedge clk);
        smp_vld = 1'b1;
        smp = SW'(v);
        @(negedge clk);
        smp_vld = 1'b0;
    endtask

    task automatic setup(input int l, input int d);
        @(negedge clk);
        dur = '0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        lvl = SW'(l);
        dur = DW'(d);
        idle(3);
    endtask

    function automatic int mag_of(input int v);
        if (v == -128) return 127;
        return (v < 0) ? -v : v;
    endfunction

    function automatic int gen(input int seed, input int i);
        if (seed % 3 == 0) return ((seed * 7 + i * 13 + i * i * 5) % 21) - 10;
        return ((seed * 37 + i * 53 + i * i * 11) % 256) - 128;
    endfunction

    initial begin
        #500us;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int lv[4] = '{5, 12, 40, 127};
        rst_n = 1'b0; smp_vld = 1'b0; clr = 1'b0;
        smp = '0; lvl = '0; dur = '0;
        idle(3);
        check(flag, 1'b0, "R1 during reset");
        rst_n = 1'b1;
        idle(2);
        check(flag, 1'b0, "R1 after reset");

        // R2 magnitude and saturation
        setup(128, 1); strobe(-128); check(flag, 1'b1, "R2 most negative gives 127 < 128");
        setup(127, 1); strobe(-128); check(flag, 1'b0, "R2 most negative gives 127, not below 127");
        setup(10, 1);  strobe(-9);   check(flag, 1'b1, "R2 |-9| below 10");
        setup(10, 1);  strobe(-10);  check(flag, 1'b0, "R2 |-10| not below 10");

        // R3 gaps between strobes
        setup(10, 3);
        strobe(0); idle(4); check(flag, 1'b0, "R3 one of three");
        strobe(0); idle(2); check(flag, 1'b0, "R3 two of three");
        strobe(0); check(flag, 1'b1, "R3 closes on third strobe");

        // R4 average boundary
        setup(10, 4); strobe(0); strobe(0); strobe(0); strobe(40);
        check(flag, 1'b0, "R4 sum equals lvl*dur");
        setup(10, 4); strobe(0); strobe(0); strobe(0); strobe(39);
        check(flag, 1'b1, "R4 sum one below lvl*dur");

        // R5 majority boundary
        setup(10, 4); strobe(10); strobe(10); strobe(0); strobe(0);
        check(flag, 1'b0, "R5 exactly half below");
        setup(10, 4); strobe(10); strobe(0); strobe(0); strobe(0);
        check(flag, 1'b1, "R5 three of four below");
        setup(10, 3); strobe(0); strobe(0); strobe(29);
        check(flag, 1'b1, "R5 two of three below, odd window");

        // R6 disabled
        setup(10, 0); repeat (5) strobe(0);
        check(flag, 1'b0, "R6 zero duration");
        setup(0, 4); repeat (4) strobe(0);
        check(flag, 1'b0, "R6 zero level");
        setup(10, 0); repeat (3) strobe(0);
        @(negedge clk); dur = 4'd4; idle(3);
        strobe(0); strobe(0); strobe(0);
        check(flag, 1'b0, "R6 strobes while off were discarded");
        strobe(0); check(flag, 1'b1, "R6 window after enabling");

        // R7 restart on config change
        setup(10, 4); strobe(0); strobe(0);
        @(negedge clk); lvl = 8'd11; smp_vld = 1'b1; smp = '0;
        @(negedge clk); smp_vld = 1'b0;
        strobe(0); strobe(0);
        check(flag, 1'b0, "R7 change-cycle strobe not counted");
        strobe(0); check(flag, 1'b0, "R7 three after restart");
        strobe(0); check(flag, 1'b1, "R7 four after restart");

        // R8 sticky and clear
        setup(10, 1); strobe(0); check(flag, 1'b1, "R8 set");
        strobe(100); idle(5); check(flag, 1'b1, "R8 holds over non-event window");
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        check(flag, 1'b0, "R8 clear pulse");
        @(negedge clk); smp_vld = 1'b1; smp = '0; clr = 1'b1;
        @(negedge clk); smp_vld = 1'b0; clr = 1'b0;
        check(flag, 1'b1, "R8 event wins over simultaneous clear");

        // R9 back to back windows
        setup(10, 2); strobe(50); strobe(50);
        check(flag, 1'b0, "R9 first window no event");
        strobe(0); check(flag, 1'b0, "R9 second window half way");
        strobe(0); check(flag, 1'b1, "R9 second window event");

        // R3 R4 R5 sweep
        for (int d = 1; d <= 8; d++) begin
            for (int li = 0; li < 4; li++) begin
                for (int seed = 0; seed < 6; seed++) begin
                    int sum = 0;
                    int blw = 0;
                    int l = lv[li];
                    setup(l, d);
                    for (int i = 0; i < d; i++) begin
                        int v = gen(seed, i);
                        int m = mag_of(v);
                        strobe(v);
                        sum += m;
                        if (m < l) blw++;
                        if (i < d - 1)
                            check(flag, 1'b0, $sformatf("R3 sweep d=%0d early at %0d", d, i));
                    end
                    check(flag, ((sum < l * d) && (2 * blw > d)) ? 1'b1 : 1'b0,
                          $sformatf("R4 R5 sweep d=%0d l=%0d seed=%0d", d, l, seed));
                end
            end
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule